// File: doc/BRIEF.md
# Load-Locked Reservation Monitor

This block tracks load-locked / store-conditional reservations for several hardware contexts that share one memory. Each context owns one reservation slot. A slot is a small state machine with two states, `SLOT_EMPTY` and `SLOT_HELD`, plus the granule address that was reserved. One memory request event can arrive per cycle. It carries a context number, a physical address and three qualifiers: locked, uncacheable and write. A locked read arms the issuing context's slot. A write that really happens removes every reservation on the same 16-byte granule. A store-conditional also returns a result code and tells the memory side whether the write should go ahead.

Slot transitions are as follows:
- `ARM`: from either state to `SLOT_HELD`, on a locked read by the owning context.
- `SNOOP_KILL`: from `SLOT_HELD` to `SLOT_EMPTY`, when a committed write hits the slot's granule.
- `SC_MISS_KILL`: from `SLOT_HELD` to `SLOT_EMPTY`, when the owner's own store-conditional fails.
- `HOLD`: the state stays as it is on any other cycle.

The block also counts consecutive store-conditional failures for each context. When a count reaches a multiple of the warning period, it pulses a warning that carries the context number, so that a possible livelock can be noticed. The memory array, address translation and caches sit outside this block.

Top module: `resv_monitor`

## Requirements
- R1: A locked read (locked=1, write=0) puts the issuing context's slot into `SLOT_HELD` and records its address granule. A store-conditional from that context to the same granule then returns code 1 with do_write=1.
- R2: Granules are compared on address bits [ADDR_W-1:4]. Addresses that differ only in bits [3:0] match, and a difference in bit 4 or above does not match.
- R3: A cacheable store-conditional (locked=1, uncached=0, write=1) succeeds only when the issuer's slot is held and its granule matches. Any other cacheable store-conditional gives do_write=0 and empties the issuer's slot. It does not disturb the slots of other contexts.
- R4: The result code of a cacheable store-conditional is the issuer's held flag as it stood on the request cycle: 1 if held, 0 if not. This holds even when the granule mismatch makes the store fail.
- R5: An uncacheable store-conditional (locked=1, uncached=1, write=1) returns code 2 with do_write=1. It clears the issuer's failure count and empties every slot whose granule matches.
- R6: A successful store-conditional or a plain store (locked=0, write=1) empties every slot whose granule matches, including the writer's own slot. Slots on other granules are left alone.
- R7: Plain reads (locked=0, write=0) never change any slot.
- R8: Each write request produces rsp_valid=1 on the cycle after it is accepted, together with rsp_code and rsp_do_write. A plain store gives code 0 with do_write=1. Read requests never raise rsp_valid.
- R9: A failed cacheable store-conditional adds one to its context's failure count. A successful or uncacheable store-conditional sets it to zero. When the count reaches a multiple of WARN_PERIOD, warn_pulse is 1 for one cycle, aligned with that request's response, and warn_ctx gives the context.
- R10: The failure count saturates at its all-ones value. Once it has saturated, further failures raise no warning until the count is cleared.
- R11: After reset every slot is `SLOT_EMPTY`, all failure counts are zero, and rsp_valid and warn_pulse are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request event present this cycle |
| req_ctx | input | CTX_W | Issuing context number |
| req_addr | input | ADDR_W | Physical address of the access |
| req_locked | input | 1 | Load-locked or store-conditional access |
| req_uncached | input | 1 | Access is to uncacheable space |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response for the write accepted one cycle earlier |
| rsp_code | output | 2 | Result code: 0 fail or plain store, 1 pass, 2 uncacheable |
| rsp_do_write | output | 1 | The write should be carried out |
| warn_pulse | output | 1 | Failure count reached a multiple of WARN_PERIOD |
| warn_ctx | output | CTX_W | Context that raised the warning |

## Verification
The bench builds the block with four contexts, a 16-bit address, WARN_PERIOD=3 and a 3-bit failure counter. The short period puts several warnings, and the reset of the count in between them, within a few dozen requests. The narrow counter reaches saturation after seven failures, so the bench can show that no warning appears at the ninth failure, where a wrapping counter would raise one. Four contexts are enough to show that a snooped write removes reservations held by others while slots on other granules survive.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

    typedef enum logic [2:0] {
        REQ_NONE,
        REQ_LOAD,
        REQ_LOAD_LOCKED,
        REQ_STORE,
        REQ_SC,
        REQ_SC_UNCACHED
    } req_kind_e;

    typedef enum logic [1:0] {
        RC_ZERO     = 2'd0,
        RC_PASS     = 2'd1,
        RC_UNCACHED = 2'd2
    } rsp_code_e;

endpackage

// File: rtl/resv_req_decode.sv
module resv_req_decode
    import resv_pkg::*;
(
    input  logic      valid,
    input  logic      locked,
    input  logic      uncached,
    input  logic      write,
    output req_kind_e kind
);

    always_comb begin
        if (!valid) begin
            kind = REQ_NONE;
        end else if (!write) begin
            kind = locked ? REQ_LOAD_LOCKED : REQ_LOAD;
        end else if (!locked) begin
            kind = REQ_STORE;
        end else begin
            kind = uncached ? REQ_SC_UNCACHED : REQ_SC;
        end
    end

endmodule

// File: rtl/resv_slot.sv
module resv_slot
    import resv_pkg::*;
#(
    parameter int GW = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          kill,
    input  logic [GW-1:0] req_gran,
    output logic          held,
    output logic          match
);

    slot_state_e   state_q, state_d;
    logic [GW-1:0] gran_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (arm)  state_d = SLOT_HELD;
            SLOT_HELD:  if (kill) state_d = SLOT_EMPTY;
                        else if (arm) state_d = SLOT_HELD;
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            gran_q  <= '0;
        end else begin
            state_q <= state_d;
            if (arm) gran_q <= req_gran;
        end
    end

    // outputs
    always_comb begin
        held  = (state_q == SLOT_HELD);
        match = (gran_q == req_gran);
    end

    // R1
    arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (held && gran_q == $past(req_gran)));

    // R6
    kill_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !arm) |=> !held);

    // R7
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!kill && !arm) |=> ($stable(held) && $stable(gran_q)));

endmodule

// File: rtl/resv_fail_track.sv
module resv_fail_track #(
    parameter int NUM_CTX     = 4,
    parameter int CTX_W       = 2,
    parameter int FAIL_CNT_W  = 32,
    parameter int WARN_PERIOD = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fail_evt,
    input  logic             clr_evt,
    input  logic [CTX_W-1:0] ctx,
    output logic             warn_pulse,
    output logic [CTX_W-1:0] warn_ctx
);

    localparam int PH_W = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(WARN_PERIOD - 1);

    logic [NUM_CTX-1:0] hit;

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
        logic [FAIL_CNT_W-1:0] cnt_q;
        logic [PH_W-1:0]       ph_q;
        logic                  sel, sat;

        always_comb begin
            sel    = (ctx == CTX_W'(i));
            sat    = (cnt_q == '1);
            hit[i] = fail_evt && sel && !sat && (ph_q == PH_LAST);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
                ph_q  <= '0;
            end else if (clr_evt && sel) begin
                cnt_q <= '0;
                ph_q  <= '0;
            end else if (fail_evt && sel && !sat) begin
                cnt_q <= cnt_q + 1'b1;
                ph_q  <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
            end
        end

        // R10
        sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sat && !(clr_evt && sel)) |=> (cnt_q == '1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn_pulse <= 1'b0;
            warn_ctx   <= '0;
        end else begin
            warn_pulse <= |hit;
            if (fail_evt) warn_ctx <= ctx;
        end
    end

    // R9
    warn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warn_pulse |-> $past(fail_evt && !clr_evt));

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int NUM_CTX     = 4,
    parameter int ADDR_W      = 32,
    parameter int GRAN_BITS   = 4,
    parameter int FAIL_CNT_W  = 32,
    parameter int WARN_PERIOD = 100000,
    localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_locked,
    input  logic              req_uncached,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic              rsp_do_write,
    output logic              warn_pulse,
    output logic [CTX_W-1:0]  warn_ctx
);

    localparam int GW = ADDR_W - GRAN_BITS;

    req_kind_e          kind;
    logic [GW-1:0]      req_gran;
    logic [NUM_CTX-1:0] held, match, own_sel, arm, kill;
    logic               own_held, own_match;
    logic               sc_ok, sc_fail, commit, uc_sc;
    logic               unused_gran_bits;

    assign req_gran         = req_addr[ADDR_W-1:GRAN_BITS];
    assign unused_gran_bits = ^req_addr[GRAN_BITS-1:0];

    resv_req_decode u_dec (
        .valid    (req_valid),
        .locked   (req_locked),
        .uncached (req_uncached),
        .write    (req_write),
        .kind     (kind)
    );

    always_comb begin
        own_held  = |(held & own_sel);
        own_match = |(match & own_sel);
        uc_sc     = (kind == REQ_SC_UNCACHED);
        sc_ok     = (kind == REQ_SC) && own_held && own_match;
        sc_fail   = (kind == REQ_SC) && !sc_ok;
        commit    = (kind == REQ_STORE) || uc_sc || sc_ok;
    end

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
        always_comb begin
            own_sel[i] = (req_ctx == CTX_W'(i));
            arm[i]     = (kind == REQ_LOAD_LOCKED) && own_sel[i];
            kill[i]    = (commit && match[i]) || (sc_fail && own_sel[i]);
        end

        resv_slot #(.GW(GW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm      (arm[i]),
            .kill     (kill[i]),
            .req_gran (req_gran),
            .held     (held[i]),
            .match    (match[i])
        );
    end

    // response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_code     <= RC_ZERO;
            rsp_do_write <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (kind)
                REQ_STORE: begin
                    rsp_valid    <= 1'b1;
                    rsp_code     <= RC_ZERO;
                    rsp_do_write <= 1'b1;
                end
                REQ_SC: begin
                    rsp_valid    <= 1'b1;
                    rsp_code     <= own_held ? RC_PASS : RC_ZERO;
                    rsp_do_write <= sc_ok;
                end
                REQ_SC_UNCACHED: begin
                    rsp_valid    <= 1'b1;
                    rsp_code     <= RC_UNCACHED;
                    rsp_do_write <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    resv_fail_track #(
        .NUM_CTX     (NUM_CTX),
        .CTX_W       (CTX_W),
        .FAIL_CNT_W  (FAIL_CNT_W),
        .WARN_PERIOD (WARN_PERIOD)
    ) u_fail (
        .clk        (clk),
        .rst_n      (rst_n),
        .fail_evt   (sc_fail),
        .clr_evt    (sc_ok || uc_sc),
        .ctx        (req_ctx),
        .warn_pulse (warn_pulse),
        .warn_ctx   (warn_ctx)
    );

    // R5
    uncached_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_locked && req_uncached)
        |=> (rsp_valid && rsp_code == 2'd2 && rsp_do_write));

    // R4
    no_resv_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == REQ_SC && !own_held)
        |=> (rsp_code == 2'd0 && !rsp_do_write));

    // R8
    rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_write));

    // R3
    one_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_fail |-> $onehot0(kill));

endmodule

// File: tb/tb_resv_monitor.sv
`timescale 1ns/100ps
module tb_resv_monitor;

    localparam int NC = 4;
    localparam int AW = 16;

    typedef struct packed {
        logic [1:0]  ctx;
        logic [15:0] addr;
        logic        lk, uc, wr;
        logic        ev;
        logic [1:0]  ec;
        logic        ed, ew;
        logic [1:0]  ewc;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'h0100, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd1},  // R1 arm c0
        '{2'd0, 16'h0108, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 2'd0, 4'd2},  // R2 low bits ignored
        '{2'd0, 16'h0100, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 4'd6},  // R6 own slot cleared
        '{2'd1, 16'h0200, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd1},
        '{2'd2, 16'h0200, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd1},
        '{2'd3, 16'h0300, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd1},
        '{2'd0, 16'h020C, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 2'd0, 4'd8},  // R8 plain store
        '{2'd1, 16'h0200, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 4'd6},  // R6 snooped away
        '{2'd3, 16'h0300, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 2'd0, 4'd6},  // R6 other granule kept
        '{2'd1, 16'h0400, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd1},
        '{2'd1, 16'h0400, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd7},  // R7 plain read
        '{2'd2, 16'h0400, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd7},
        '{2'd1, 16'h0410, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 2'd0, 4'd4},  // R4 held, mismatch
        '{2'd1, 16'h0400, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 2'd1, 4'd3},  // R3 own cleared; R9 warn
        '{2'd2, 16'h0500, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd1},
        '{2'd2, 16'h0500, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 1'b0, 2'd0, 4'd5},  // R5 uncached
        '{2'd2, 16'h0500, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 4'd5},  // R5 slot cleared
        '{2'd1, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 4'd9},
        '{2'd1, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 1'b0, 2'd0, 4'd5},  // R5 count reset
        '{2'd1, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 4'd9},
        '{2'd1, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 4'd9},
        '{2'd1, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 2'd1, 4'd9},  // R9 warn after reset
        '{2'd0, 16'h0700, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd1},
        '{2'd1, 16'h0700, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 4'd3},  // R3 foreign SC fails
        '{2'd0, 16'h0700, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 2'd0, 4'd3}   // R3 owner unaffected
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_ctx = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_locked = 1'b0, req_uncached = 1'b0, req_write = 1'b0;
    logic          rsp_valid, rsp_do_write, warn_pulse;
    logic [1:0]    rsp_code, warn_ctx;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    resv_monitor #(
        .NUM_CTX(NC), .ADDR_W(AW), .GRAN_BITS(4), .FAIL_CNT_W(3), .WARN_PERIOD(3)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
        .req_addr(req_addr), .req_locked(req_locked), .req_uncached(req_uncached),
        .req_write(req_write), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_do_write(rsp_do_write), .warn_pulse(warn_pulse), .warn_ctx(warn_ctx)
    );

    task automatic apply(input vec_t v);
        logic ok;
        @(negedge clk);
        req_valid    = 1'b1;
        req_ctx      = v.ctx;
        req_addr     = v.addr;
        req_locked   = v.lk;
        req_uncached = v.uc;
        req_write    = v.wr;
        @(posedge clk);
        #1;
        ok = (rsp_valid == v.ev) && (warn_pulse == v.ew);
        if (v.ev) ok = ok && (rsp_code == v.ec) && (rsp_do_write == v.ed);
        if (v.ew) ok = ok && (warn_ctx == v.ewc);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d ctx%0d addr %h: got v=%0b c=%0d w=%0b warn=%0b/%0d exp v=%0b c=%0d w=%0b warn=%0b/%0d",
                     v.req, v.ctx, v.addr, rsp_valid, rsp_code, rsp_do_write, warn_pulse, warn_ctx,
                     v.ev, v.ec, v.ed, v.ew, v.ewc);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        n_chk++;
        if (rsp_valid !== 1'b0 || warn_pulse !== 1'b0) begin   // R11
            n_bad++;
            $display("FAIL R11 in reset: got v=%0b warn=%0b exp 0 0", rsp_valid, warn_pulse);
        end
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        for (int k = 0; k < NV; k++) apply(VECS[k]);
        idle();

        // R11: reservation armed before reset is gone afterwards
        apply('{2'd3, 16'h0900, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd11});
        do_reset();
        apply('{2'd3, 16'h0900, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 4'd11});

        // R10: saturation at 7 stops warnings; a wrapping count would warn at the 9th
        do_reset();
        for (int k = 1; k <= 9; k++) begin
            apply('{2'd2, 16'h0800, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0,
                    (k == 3 || k == 6), 2'd2, 4'd10});
        end

        // R8: a read gives no response even right after a write
        apply('{2'd0, 16'h0A00, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 2'd0, 4'd8});
        apply('{2'd0, 16'h0A00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd8});
        idle();
        @(negedge clk);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule